// File: doc/BRIEF.md
# Programmable Odd/Even Clock Divider Stage

This block divides an input clock by a ratio that software sets through one 32-bit control word. The word carries two explicit phase lengths: how many input cycles the output stays low and how many it stays high. The ratio is their sum. For odd ratios a half-cycle select moves the output's falling edge onto the falling edge of the input clock, so a divide-by-3 or divide-by-7 output is still close to 50% duty. A bypass bit hands the input clock straight to the output for a ratio of one.

A write is not applied at once. It waits for the output period in progress to finish, so no shortened pulse appears. A lock flag gives the handshake. It drops in the cycle after a write that requests an update, stays low while the change waits, and rises a fixed number of input cycles after the new setting has taken effect. A separate bit in the word allows a value to be stored and read back without being applied.

Top module: `phase_clk_div`

## Requirements
- R1: Control word fields: low count in bits [5:0], high count in bits [11:6], half-cycle select in bit 12, bypass in bit 13, hold (store without applying) in bit 14. The read port returns the last written bits [14:0], and bits [31:15] always read as 0.
- R2: With bypass and half-cycle select both 0, every output period is `high` input cycles high followed by `low` input cycles low.
- R3: With the half-cycle select at 1 and bypass at 0, the high phase lasts `high` + 0.5 input cycles and the low phase `low` - 0.5 input cycles, so an odd ratio N encoded as low = (N>>1)+1, high = N>>1 gives two equal halves.
- R4: With bypass at 1 the output follows the input clock, high and low for half an input period each.
- R5: With bypass at 0, a low or high count of 0 behaves as a count of 1.
- R6: A write with the hold bit at 0 pulls the lock flag low in the next cycle.
- R7: A new setting takes effect only at the end of the output period in progress; that period completes with the old phase lengths.
- R8: Once the new setting takes effect, the lock flag stays low for 16 more input cycles and then goes high; it is never low for fewer than 16 cycles after a write.
- R9: A write with the hold bit at 1 stores the word for read-back but leaves the output waveform and the lock flag unchanged.
- R10: After reset the control word reads 0x041 (low 1, high 1, divide by 2), the output divides by 2 and the lock flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control word, sampled on the rising edge of clkIn |
| wrData | input | 32 | Control word to store |
| rdData | output | 32 | Stored control word, unused bits zero |
| lockOut | output | 1 | Lock flag, high when the output runs on the stored setting |
| clkOut | output | 1 | Divided clock |

## Verification
The divider is driven with directed words covering even ratios, odd ratios using the half-cycle select, bypass, and zero phase counts. A seeded random series of ratios from 1 to 40 follows, each encoded the way software encodes it. The bench times every edge of the output: the high and low durations separate a wrong phase count from a wrong half-cycle placement, which a plain period measurement would not expose. A write landing early in a long high phase shows whether the old period is cut short. A held write followed by the same word without the hold bit shows whether storing and applying are kept apart. The number of low lock cycles after each write is compared against the 16-cycle minimum and an upper bound set by the old period.

// File: rtl/phase_clk_div_pkg.sv
package phase_clk_div_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 6;
  localparam int LOW_LSB   = 0;
  localparam int HIGH_LSB  = CNT_W;
  localparam int EDGE_BIT  = 2 * CNT_W;
  localparam int BYP_BIT   = EDGE_BIT + 1;
  localparam int HOLD_BIT  = BYP_BIT + 1;
  localparam int USED_W    = HOLD_BIT + 1;

  typedef struct packed {
    logic [CNT_W-1:0] lowCnt;
    logic [CNT_W-1:0] highCnt;
    logic             edgeSel;
    logic             bypass;
  } divCfg_t;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  function automatic divCfg_t decodeWord(input logic [BYP_BIT:0] w);
    divCfg_t c;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    lo = w[LOW_LSB +: CNT_W];
    hi = w[HIGH_LSB +: CNT_W];
    c.lowCnt  = (lo == '0) ? CNT_W'(1) : lo;
    c.highCnt = (hi == '0) ? CNT_W'(1) : hi;
    c.edgeSel = w[EDGE_BIT];
    c.bypass  = w[BYP_BIT];
    return c;
  endfunction
endpackage

// File: rtl/phase_clk_div_ctrl.sv
module phase_clk_div_ctrl
  import phase_clk_div_pkg::*;
#(
  parameter int                LOCK_CYCLES = 16,
  parameter logic [USED_W-1:0] RESET_WORD  = 15'h0041
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [USED_W-1:0] wrData,
  input  logic              periodEnd,
  output logic [USED_W-1:0] storedWord,
  output divCfg_t           nextCfg,
  output ctrlStrobe_t       strobe,
  output logic              lockFlag
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);

  logic              pending;
  logic              counting;
  logic [LOCK_W-1:0] lockCnt;

  assign strobe.load = pending & periodEnd;
  assign nextCfg     = decodeWord(storedWord[BYP_BIT:0]);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      storedWord <= RESET_WORD;
      pending    <= 1'b0;
      counting   <= 1'b0;
      lockCnt    <= '0;
      lockFlag   <= 1'b1;
    end else begin
      if (strobe.load) begin
        pending  <= 1'b0;
        counting <= 1'b1;
        lockCnt  <= '0;
      end else if (counting) begin
        if (lockCnt == LOCK_LAST) begin
          counting <= 1'b0;
          lockFlag <= 1'b1;
        end else begin
          lockCnt <= lockCnt + LOCK_W'(1);
        end
      end
      if (wrEn) begin
        storedWord <= wrData;
        if (!wrData[HOLD_BIT]) begin
          pending  <= 1'b1;
          counting <= 1'b0;
          lockFlag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/phase_clk_div_datapath.sv
module phase_clk_div_datapath
  import phase_clk_div_pkg::*;
#(
  parameter divCfg_t RESET_CFG = decodeWord(14'h0041)
) (
  input  logic        clkIn,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  divCfg_t     nextCfg,
  output logic        periodEnd,
  output logic        clkOut
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  divCfg_t          cfg;
  logic [CNT_W-1:0] cnt;
  logic             posPhase;
  logic             negPhase;
  logic             lastLow;
  logic             lastHigh;
  logic             divClk;

  assign lastLow   = (cnt == cfg.lowCnt);
  assign lastHigh  = (cnt == cfg.highCnt);
  assign periodEnd = cfg.bypass | (posPhase & lastHigh);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cfg      <= RESET_CFG;
      cnt      <= CNT_ONE;
      posPhase <= 1'b0;
    end else if (strobe.load) begin
      cfg      <= nextCfg;
      cnt      <= CNT_ONE;
      posPhase <= 1'b0;
    end else if (cfg.bypass) begin
      cnt      <= CNT_ONE;
      posPhase <= 1'b0;
    end else if (!posPhase) begin
      if (lastLow) begin
        posPhase <= 1'b1;
        cnt      <= CNT_ONE;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end else begin
      if (lastHigh) begin
        posPhase <= 1'b0;
        cnt      <= CNT_ONE;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  // Half-cycle delayed copy used to stretch the high phase for odd ratios.
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) negPhase <= 1'b0;
    else       negPhase <= posPhase;
  end

  assign divClk = cfg.edgeSel ? (posPhase | negPhase) : posPhase;
  assign clkOut = cfg.bypass ? clkIn : divClk;
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div
  import phase_clk_div_pkg::*;
#(
  parameter int                LOCK_CYCLES = 16,
  parameter logic [USED_W-1:0] RESET_WORD  = 15'h0041
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              lockOut,
  output logic              clkOut
);
  localparam divCfg_t RESET_CFG = decodeWord(RESET_WORD[BYP_BIT:0]);

  logic              unusedHiBits;
  logic [USED_W-1:0] storedWord;
  divCfg_t           nextCfg;
  ctrlStrobe_t       strobe;
  logic              periodEnd;

  assign unusedHiBits = ^wrData[WORD_W-1:USED_W];
  assign rdData       = {{(WORD_W-USED_W){1'b0}}, storedWord};

  phase_clk_div_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .RESET_WORD (RESET_WORD)
  ) u_ctrl (
    .clkIn     (clkIn),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData[USED_W-1:0]),
    .periodEnd (periodEnd),
    .storedWord(storedWord),
    .nextCfg   (nextCfg),
    .strobe    (strobe),
    .lockFlag  (lockOut)
  );

  phase_clk_div_datapath #(
    .RESET_CFG(RESET_CFG)
  ) u_dp (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .strobe   (strobe),
    .nextCfg  (nextCfg),
    .periodEnd(periodEnd),
    .clkOut   (clkOut)
  );
endmodule

// File: rtl/phase_clk_div_checker.sv
module phase_clk_div_checker #(
  parameter int LOCK_CYCLES = 16
) (
  input logic        clkIn,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        lockOut
);
  localparam int RUN_W = $clog2(LOCK_CYCLES + 1);

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN)                                lowRun <= '0;
    else if (lockOut)                         lowRun <= '0;
    else if (lowRun != RUN_W'(LOCK_CYCLES))   lowRun <= lowRun + RUN_W'(1);
  end

  p_readback_r1: assert property (@(posedge clkIn) disable iff (!rstN)
    wrEn |=> rdData == {17'b0, $past(wrData[14:0])});

  p_upper_zero_r1: assert property (@(posedge clkIn) disable iff (!rstN)
    rdData[31:15] == 17'b0);

  p_lock_drop_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrEn && !wrData[14]) |=> !lockOut);

  p_hold_keeps_lock_r9: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrEn && wrData[14] && lockOut) |=> lockOut);

  p_lock_min_low_r8: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(lockOut) |-> lowRun >= RUN_W'(LOCK_CYCLES));
endmodule

bind phase_clk_div phase_clk_div_checker #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clkIn  (clkIn),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .lockOut(lockOut)
);

// File: tb/test_phase_clk_div.sv
module test_phase_clk_div;
  localparam time HALF = 10;
  localparam int  LOCK = 16;

  logic        clkIn = 1'b0;
  logic        rstN  = 1'b0;
  logic        wrEn  = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        lockOut;
  logic        clkOut;

  int checks   = 0;
  int failures = 0;
  int curPeriod = 2;
  time riseT = 0, fallT = 0, highT = 0, lowT = 0;

  always #(HALF) clkIn = ~clkIn;

  phase_clk_div i_phase_clk_div (
    .clkIn(clkIn), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .lockOut(lockOut), .clkOut(clkOut)
  );

  always @(posedge clkOut) begin lowT = $time - fallT; riseT = $time; end
  always @(negedge clkOut) begin highT = $time - riseT; fallT = $time; end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encRatio(input int n);
    logic [31:0] w = '0;
    if (n == 1) w[13] = 1'b1;
    else begin
      w[5:0]  = 6'((n % 2) ? (n >> 1) + 1 : n / 2);
      w[11:6] = 6'(n >> 1);
      w[12]   = 1'(n % 2);
    end
    return w;
  endfunction

  function automatic longint expHigh(input logic [31:0] w);
    longint hi = (w[11:6] == 0) ? 1 : w[11:6];
    if (w[13]) return HALF;
    return hi * 2 * HALF + (w[12] ? HALF : 0);
  endfunction

  function automatic longint expLow(input logic [31:0] w);
    longint lo = (w[5:0] == 0) ? 1 : w[5:0];
    if (w[13]) return HALF;
    return lo * 2 * HALF - (w[12] ? HALF : 0);
  endfunction

  function automatic int periodOf(input logic [31:0] w);
    if (w[13]) return 1;
    return int'((expHigh(w) + expLow(w)) / (2 * HALF));
  endfunction

  task automatic writeWord(input logic [31:0] w);
    @(negedge clkIn); wrEn = 1'b1; wrData = w;
    @(negedge clkIn); wrEn = 1'b0;
  endtask

  task automatic measure(output longint h, output longint l);
    @(posedge clkOut); @(posedge clkOut); #1 l = lowT;
    @(negedge clkOut); #1 h = highT;
  endtask

  task automatic waitLock(input string req);
    int n = 0;
    while (!lockOut) begin @(negedge clkIn); n++; end
    checks++;
    if (n < LOCK || n > LOCK + curPeriod + 3) begin
      failures++;
      $display("FAIL %s lock low cycles actual=%0d expected=%0d..%0d", req, n, LOCK, LOCK + curPeriod + 3);
    end
  endtask

  task automatic applyWord(input logic [31:0] w, input string req);
    longint h, l;
    writeWord(w);
    chk("R6", "lock after write", lockOut, 0);
    waitLock("R8");
    curPeriod = periodOf(w);
    chk("R1", "readback", rdData, {17'b0, w[14:0]});
    measure(h, l);
    chk(req, "high time", h, expHigh(w));
    chk(req, "low time", l, expLow(w));
  endtask

  initial begin
    #(2 * HALF * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint h, l;
    int bad;
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clkIn);
    rstN = 1'b1;
    @(negedge clkIn);
    // R10 reset state
    chk("R10", "lock at reset", lockOut, 1);
    chk("R10", "word at reset", rdData, 32'h41);
    measure(h, l);
    chk("R10", "reset high", h, 20);
    chk("R10", "reset low", l, 20);

    applyWord(encRatio(4), "R2");
    applyWord(encRatio(3), "R3");
    applyWord(encRatio(7), "R3");
    applyWord(encRatio(1), "R4");
    applyWord(encRatio(6), "R2");
    // R5 zero counts
    applyWord(32'h0, "R5");
    applyWord(32'h0C0, "R5");
    // R1 unused upper bits ignored and read as zero
    w = 32'hABCD_8000 | encRatio(8);
    writeWord(w);
    waitLock("R8");
    curPeriod = 8;
    chk("R1", "upper bits read zero", rdData, {17'b0, w[14:0]});
    measure(h, l);
    chk("R1", "upper bits no effect high", h, 80);

    // R9 hold bit: stored, not applied
    applyWord(encRatio(6), "R2");
    w = encRatio(10) | 32'h4000;
    writeWord(w);
    bad = 0;
    repeat (40) begin @(negedge clkIn); if (!lockOut) bad++; end
    chk("R9", "lock stays high", bad, 0);
    chk("R9", "held word readback", rdData, {17'b0, w[14:0]});
    measure(h, l);
    chk("R9", "output unchanged high", h, 60);
    chk("R9", "output unchanged low", l, 60);
    applyWord(encRatio(10), "R2");

    // R7 old period completes
    applyWord(encRatio(40), "R2");
    @(posedge clkOut);
    writeWord(encRatio(4));
    @(negedge clkOut); #1;
    chk("R7", "old high phase kept", highT, 400);
    waitLock("R8");
    curPeriod = 4;
    measure(h, l);
    chk("R7", "new high after period end", h, 40);

    // Random ratios
    for (int i = 0; i < 16; i++) begin
      int n = 1 + int'($urandom % 40);
      applyWord(encRatio(n), (n == 1) ? "R4" : ((n % 2) ? "R3" : "R2"));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule